// File: doc/BRIEF.md
# Counted Loop Branch Controller

This block resolves the closing branch of a counted, software-pipelined loop. It keeps two counters. The trip counter holds the number of kernel iterations still to issue. The drain counter holds the number of pipeline stages still to empty once the kernel has finished. Each loop-branch issue reads the two counters and places the loop in one of four phases: kernel, draining, last drain stage, or finished. From the phase it updates the counters and gives a branch direction, a stage-valid bit for the first rotating predicate, and a rotate strobe.

There are two branch flavours. The continue flavour is taken while work remains. The exit flavour is taken when the loop is over. For any counter state the two flavours take opposite directions. The stage-valid bit is 1 only while kernel iterations remain. Predicated stages therefore switch on while the pipeline fills and switch off while it drains. A load port writes both counters before the loop starts. Outputs are registered and appear for one cycle, on the cycle after the issue.

Top module: `loop_branch_ctl`

## Requirements
- R1: When a branch issues with a nonzero trip count, the trip count goes down by one and the drain count holds. On the next cycle `pred_value`=1 and `rotate`=1.
- R2: When a branch issues with a trip count of zero and a drain count above one, the drain count goes down by one and the trip count holds. On the next cycle `pred_value`=0 and `rotate`=1.
- R3: When a branch issues with a trip count of zero and a drain count of exactly one, the drain count becomes zero. On the next cycle `pred_value`=0 and `rotate`=1.
- R4: When a branch issues with both counts at zero, neither count changes. On the next cycle `rotate`=0, `pred_value`=0 and `pred_write` is still 1.
- R5: With `br_is_exit`=0 (continue flavour), `taken` is 1 exactly when the trip count is nonzero or the drain count is above one. With `br_is_exit`=1 (exit flavour), `taken` is the complement of that condition.
- R6: For each issue, `taken`, `pred_value`, `pred_write` and `rotate` are registered and valid for the single cycle after the issuing clock edge. `pred_write` is 1 for every issued loop branch.
- R7: When `load_en`=1, both counters take `load_trip` and `load_drain`. If a branch issues in the same cycle, that branch decides and reports from the old counts, and the next branch uses the loaded counts.
- R8: In a cycle with no branch and no load, both counters hold. On the following cycle `taken`, `pred_value`, `pred_write` and `rotate` are 0.
- R9: After a synchronous active-low reset both counters are zero and all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Write both counters this cycle |
| load_trip | input | CNT_W | Value loaded into the trip counter |
| load_drain | input | CNT_W | Value loaded into the drain counter |
| br_valid | input | 1 | A loop branch issues this cycle |
| br_is_exit | input | 1 | 0 = continue flavour, 1 = exit flavour |
| taken | output | 1 | Branch direction, one cycle after issue |
| pred_value | output | 1 | Stage-valid bit for the first rotating predicate |
| pred_write | output | 1 | Write strobe for the stage-valid bit |
| rotate | output | 1 | Rotate strobe for the rotating registers |

## Verification
The assertions assume that `br_valid` and `load_en` are known after reset. They also assume that a load asserted together with a branch is meant to affect only later branches. The bench drives all inputs at the falling edge. It clears every strobe after each one-cycle pulse and reads outputs at the next falling edge. Counter state is never read directly. It is inferred from the phases that later branches report, while the bench tracks its own model of the two counts.

// File: rtl/lbc_pkg.sv
// Shared types for the counted loop branch controller.
package lbc_pkg;
    // Loop phase derived from the two counters at issue time.
    typedef enum logic [1:0] {
        PH_KERNEL = 2'd0,  // trip count nonzero
        PH_DRAIN  = 2'd1,  // trip zero, drain above one
        PH_LAST   = 2'd2,  // trip zero, drain exactly one
        PH_DONE   = 2'd3   // both zero
    } loop_phase_e;
endpackage

// File: rtl/lbc_phase_decode.sv
// Classifies the counter pair into a loop phase.
// Assumes: purely combinational; counters are unsigned.
module lbc_phase_decode
    import lbc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0] trip_cnt,
    input  logic [CNT_W-1:0] drain_cnt,
    output loop_phase_e      phase
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Priority: trip count first, then drain count magnitude.
    always_comb begin
        if (trip_cnt != '0)        phase = PH_KERNEL;
        else if (drain_cnt > ONE)  phase = PH_DRAIN;
        else if (drain_cnt == ONE) phase = PH_LAST;
        else                       phase = PH_DONE;
    end
endmodule

// File: rtl/lbc_counters.sv
// Holds the trip and drain counters and steps them per issued branch.
// Assumes: load has priority over the step; the step uses the phase of
// the current (old) counts.
module lbc_counters
    import lbc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_trip,
    input  logic [CNT_W-1:0] load_drain,
    input  logic             step,
    input  loop_phase_e      phase,
    output logic [CNT_W-1:0] trip_q,
    output logic [CNT_W-1:0] drain_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Counter update: reset, load, or phase-directed decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_q  <= '0;
            drain_q <= '0;
        end else if (load_en) begin
            trip_q  <= load_trip;
            drain_q <= load_drain;
        end else if (step) begin
            unique case (phase)
                PH_KERNEL:         trip_q  <= trip_q - ONE;
                PH_DRAIN, PH_LAST: drain_q <= drain_q - ONE;
                default:           ;
            endcase
        end
    end

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_en) |=> ($stable(trip_q) && $stable(drain_q)));

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (trip_q == $past(load_trip) && drain_q == $past(load_drain)));

    // R4
    done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en && phase == PH_DONE) |=> (trip_q == '0 && drain_q == '0));
endmodule

// File: rtl/loop_branch_ctl.sv
// Top of the counted loop branch controller. Registers direction,
// stage-valid bit, its write strobe and the rotate strobe one cycle
// after each loop-branch issue.
// Assumes: at most one loop branch per cycle; outputs are one-cycle pulses.
module loop_branch_ctl
    import lbc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_trip,
    input  logic [CNT_W-1:0] load_drain,
    input  logic             br_valid,
    input  logic             br_is_exit,
    output logic             taken,
    output logic             pred_value,
    output logic             pred_write,
    output logic             rotate
);
    logic [CNT_W-1:0] trip_q;
    logic [CNT_W-1:0] drain_q;
    loop_phase_e      phase;
    logic             keep_going;

    lbc_phase_decode #(.CNT_W(CNT_W)) u_decode (
        .trip_cnt  (trip_q),
        .drain_cnt (drain_q),
        .phase     (phase)
    );

    lbc_counters #(.CNT_W(CNT_W)) u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_trip  (load_trip),
        .load_drain (load_drain),
        .step       (br_valid),
        .phase      (phase),
        .trip_q     (trip_q),
        .drain_q    (drain_q)
    );

    // Loop still has work after this branch (kernel or non-final drain).
    assign keep_going = (phase == PH_KERNEL) || (phase == PH_DRAIN);

    // Output register: one-cycle pulses per issued loop branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken      <= 1'b0;
            pred_value <= 1'b0;
            pred_write <= 1'b0;
            rotate     <= 1'b0;
        end else if (br_valid) begin
            taken      <= br_is_exit ? !keep_going : keep_going;
            pred_value <= (phase == PH_KERNEL);
            pred_write <= 1'b1;
            rotate     <= (phase != PH_DONE);
        end else begin
            taken      <= 1'b0;
            pred_value <= 1'b0;
            pred_write <= 1'b0;
            rotate     <= 1'b0;
        end
    end

    // R6
    write_every_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> pred_write);

    // R1
    valid_needs_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_value |-> (rotate && pred_write));

    // R8
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> (!pred_write && !rotate && !taken));

    // R4
    done_no_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && trip_q == '0 && drain_q == '0) |=> (!rotate && !pred_value));
endmodule

// File: tb/sim_loop_branch_ctl.sv
module sim_loop_branch_ctl;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic [W-1:0] load_trip = '0;
    logic [W-1:0] load_drain = '0;
    logic         br_valid = 1'b0;
    logic         br_is_exit = 1'b0;
    logic         taken, pred_value, pred_write, rotate;

    int n_chk = 0;
    int n_fail = 0;
    logic [W-1:0] m_trip = '0;
    logic [W-1:0] m_drain = '0;

    always #4 clk = ~clk;  // 125 MHz

    loop_branch_ctl #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .load_en(load_en),
        .load_trip(load_trip), .load_drain(load_drain),
        .br_valid(br_valid), .br_is_exit(br_is_exit),
        .taken(taken), .pred_value(pred_value),
        .pred_write(pred_write), .rotate(rotate)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one branch (optionally with a simultaneous load); check outputs.
    task automatic issue(input logic ex, input logic ld, input logic [W-1:0] lt,
                         input logic [W-1:0] lddr, input string req);
        logic e_tk, e_pv, e_rot, more;
        more  = (m_trip != 0) || (m_drain > 1);
        e_tk  = ex ? !more : more;
        e_pv  = (m_trip != 0);
        e_rot = (m_trip != 0) || (m_drain != 0);
        if (ld) begin m_trip = lt; m_drain = lddr; end
        else if (m_trip != 0) m_trip = m_trip - 1;
        else if (m_drain != 0) m_drain = m_drain - 1;
        @(negedge clk);
        br_valid = 1'b1; br_is_exit = ex; load_en = ld; load_trip = lt; load_drain = lddr;
        @(negedge clk);
        br_valid = 1'b0; load_en = 1'b0;
        check({req, " R5 taken"}, W'(taken), W'(e_tk));
        check({req, " pred_value"}, W'(pred_value), W'(e_pv));
        check({req, " R6 pred_write"}, W'(pred_write), W'(1));
        check({req, " rotate"}, W'(rotate), W'(e_rot));
    endtask

    task automatic load(input logic [W-1:0] lt, input logic [W-1:0] lddr);
        @(negedge clk);
        load_en = 1'b1; load_trip = lt; load_drain = lddr;
        @(negedge clk);
        load_en = 1'b0;
        m_trip = lt; m_drain = lddr;
        check("R8 no strobe on load", W'(pred_write | rotate | taken), W'(0));
    endtask

    // Run a loop to completion with one flavour; count rotations.
    task automatic run_loop(input logic ex, input logic [W-1:0] lt, input logic [W-1:0] lddr,
                            input string req);
        int rots = 0;
        load(lt, lddr);
        for (int i = 0; i < 64; i++) begin
            issue(ex, 1'b0, '0, '0, req);
            if (rotate) rots++;
            if (m_trip == 0 && m_drain == 0) break;
        end
        check({req, " rotation count"}, W'(rots), lt + lddr);
        issue(ex, 1'b0, '0, '0, {req, " R4 done"});
    endtask

    task automatic test_reset();
        check("R9 taken", W'(taken), W'(0));
        check("R9 pred_write", W'(pred_write), W'(0));
        check("R9 rotate", W'(rotate), W'(0));
        issue(1'b0, 1'b0, '0, '0, "R9 zero counters R4");
    endtask

    task automatic test_idle_hold();
        load(W'(1), W'(1));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R8 idle outputs", W'(pred_write | rotate | taken | pred_value), W'(0));
        end
        issue(1'b0, 1'b0, '0, '0, "R8 held R1");
        issue(1'b0, 1'b0, '0, '0, "R3 last");
        issue(1'b1, 1'b0, '0, '0, "R4 exit done");
    endtask

    task automatic test_collision();
        load(W'(2), W'(1));
        issue(1'b0, 1'b1, W'(0), W'(5), "R7 old counts R1");
        issue(1'b0, 1'b0, '0, '0, "R7 new counts R2");
    endtask

    task automatic test_wide();
        load({W{1'b1}}, W'(3));
        issue(1'b1, 1'b0, '0, '0, "R1 max trip");
        issue(1'b0, 1'b0, '0, '0, "R1 max trip minus one");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_loop(1'b0, W'(3), W'(3), "R1 R2 R3 continue");
        run_loop(1'b1, W'(1), W'(2), "R5 exit");
        run_loop(1'b0, W'(0), W'(4), "R2 drain only");
        test_idle_hold();
        test_collision();
        test_wide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule